// File: doc/BRIEF.md
# Nibble-Tagged Register Access Port

This block decodes a stream of command bytes into accesses to a small bank of 8-bit registers. Every command byte carries a 4-bit tag in its upper half and a 4-bit payload in its lower half. A register address is built from two address commands, low nibble first. A write value is built the same way: a data-low command loads a holding nibble, and a data-high command supplies the upper nibble and commits the byte. A read command returns the addressed byte on an output byte stream. The read-with-increment command also advances the address, so one address setup serves a burst of reads over consecutive registers. Every committed write advances the address as well, so a run of data pairs fills consecutive registers.

The register space has three regions. The lowest `NUM_RW` addresses are writable flops, and their contents appear on `reg_out`. The next `NUM_STATUS` addresses read bytes of `status_in` and are read-only. All addresses above those read as zero.

A two-state controller sequences the port. In `ST_ACCEPT` the port takes one command per cycle. A read moves it to `ST_DRAIN` (transition *read accepted*). There it presents the byte until the consumer takes it, and then returns to `ST_ACCEPT` (transition *byte taken*). In every other case `ST_ACCEPT` stays where it is (*command consumed*), and `ST_DRAIN` holds while `out_ready` is low (*stalled*).

Top module: `nibreg_port`

## Requirements
- R1: During and after reset the address and the holding nibble are zero, every writable register is zero, `out_valid` is low and `in_ready` is high.
- R2: The tag is `in_data[7:4]`. Tag 0x0 loads address bits [3:0] from `in_data[3:0]`, and tag 0x1 loads address bits [7:4]. The other address half is kept.
- R3: Tag 0x2 stores `in_data[3:0]` as the holding nibble. Tag 0x3 writes `{in_data[3:0], holding nibble}` into the addressed writable register, and `reg_out[8*a +: 8]` shows the new value in the cycle after the command is accepted.
- R4: Each accepted tag 0x3 command increments the address by one, modulo 256, so consecutive data pairs land in consecutive registers.
- R5: Tag 0x4 presents the addressed byte on `out_data` with `out_valid` high in the cycle after acceptance, and leaves the address unchanged.
- R6: Tag 0x5 returns the addressed byte in the same way as tag 0x4 and then increments the address by one.
- R7: Address `NUM_RW+k` reads `status_in[8*k +: 8]`. A tag 0x3 write to a status or unmapped address changes no register. An address at or above `NUM_RW+NUM_STATUS` reads 0x00.
- R8: Tags 0x6 to 0xF are consumed without effect: the address, the holding nibble and the registers keep their values, and no byte is output.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and `in_ready` stays low, so no command is taken. The byte is released in the first cycle in which `out_ready` is high.
- R10: The holding nibble persists across writes, so a tag 0x3 command with no fresh tag 0x2 before it reuses the last low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A command byte is offered |
| in_ready | output | 1 | The port takes the offered byte this cycle |
| in_data | input | 8 | Command byte: tag in [7:4], payload in [3:0] |
| out_valid | output | 1 | A read result is presented |
| out_ready | input | 1 | The consumer takes the read result |
| out_data | output | 8 | Read result byte |
| status_in | input | 8*NUM_STATUS | Read-only status bytes, byte k at address NUM_RW+k |
| reg_out | output | 8*NUM_RW | Contents of the writable registers, register a in bits [8a+7:8a] |

## Verification
A wrong address or holding nibble does not show up when it goes wrong. It becomes visible at the next read, as a wrong `out_data` byte one cycle after that read is accepted. For a write, it shows up one cycle after the data-high byte, as a changed byte in the wrong lane of `reg_out`. The bench compares the whole of `reg_out` after every command and reads back through bursts. A corrupted address or hold nibble is therefore caught within a few commands. A controller stuck in the wrong state shows at once: either `in_ready` and `out_valid` are both high, or the handshake never completes, which is caught within one stall window.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    // Tag values carried in the upper nibble of each command byte.
    localparam logic [NIB_W-1:0] TAG_ADDR_LO  = 4'h0;
    localparam logic [NIB_W-1:0] TAG_ADDR_HI  = 4'h1;
    localparam logic [NIB_W-1:0] TAG_DATA_LO  = 4'h2;
    localparam logic [NIB_W-1:0] TAG_DATA_WR  = 4'h3;
    localparam logic [NIB_W-1:0] TAG_READ     = 4'h4;
    localparam logic [NIB_W-1:0] TAG_READ_INC = 4'h5;

    typedef struct packed {
        logic set_lo;
        logic set_hi;
        logic hold;
        logic write;
        logic read;
        logic bump;
    } cmd_t;

    typedef enum logic [0:0] {
        ST_ACCEPT = 1'b0,
        ST_DRAIN  = 1'b1
    } port_state_t;

endpackage

// File: rtl/nrp_cmd_decode.sv
module nrp_cmd_decode
    import nrp_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_t              cmd,
    output logic [NIB_W-1:0]  payload
);

    logic [NIB_W-1:0] tag;

    assign tag     = cmd_byte[BYTE_W-1:NIB_W];
    assign payload = cmd_byte[NIB_W-1:0];

    always_comb begin
        cmd = '0;
        unique case (tag)
            TAG_ADDR_LO:  cmd.set_lo = 1'b1;
            TAG_ADDR_HI:  cmd.set_hi = 1'b1;
            TAG_DATA_LO:  cmd.hold   = 1'b1;
            TAG_DATA_WR: begin
                cmd.write = 1'b1;
                cmd.bump  = 1'b1;
            end
            TAG_READ:     cmd.read   = 1'b1;
            TAG_READ_INC: begin
                cmd.read = 1'b1;
                cmd.bump = 1'b1;
            end
            default:      cmd = '0;
        endcase
    end

endmodule

// File: rtl/nrp_regbank.sv
module nrp_regbank
    import nrp_pkg::*;
#(
    parameter int NUM_RW     = 16,
    parameter int NUM_STATUS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [BYTE_W-1:0]            addr,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic [NUM_STATUS*BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0]            rd_data,
    output logic [NUM_RW*BYTE_W-1:0]     regs_flat
);

    localparam int STATUS_BASE = NUM_RW;

    // One flop byte per writable register.
    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (int'(addr) == g)) begin
                q <= wr_data;
            end
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = q;
    end

    // Read mux over both regions; unmapped addresses give zero.
    always_comb begin
        rd_data = '0;
        for (int a = 0; a < NUM_RW; a++) begin
            if (int'(addr) == a) begin
                rd_data = regs_flat[a*BYTE_W +: BYTE_W];
            end
        end
        for (int k = 0; k < NUM_STATUS; k++) begin
            if (int'(addr) == STATUS_BASE + k) begin
                rd_data = status_in[k*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/nrp_seq.sv
module nrp_seq
    import nrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  cmd_t              cmd,
    input  logic [NIB_W-1:0]  payload,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic [BYTE_W-1:0] addr_q,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);

    port_state_t st_q;
    port_state_t st_d;
    logic        take;
    logic [NIB_W-1:0] hold_q;

    assign take = in_valid && in_ready;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_ACCEPT;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACCEPT: if (take && cmd.read) st_d = ST_DRAIN;
            ST_DRAIN:  if (out_ready)        st_d = ST_ACCEPT;
            default:   st_d = ST_ACCEPT;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (st_q)
            ST_ACCEPT: in_ready  = 1'b1;
            ST_DRAIN:  out_valid = 1'b1;
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    assign wr_en   = take && cmd.write;
    assign wr_data = {payload, hold_q};

    // Address, holding nibble and read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            hold_q   <= '0;
            out_data <= '0;
        end else if (take) begin
            if (cmd.set_lo) addr_q[NIB_W-1:0]      <= payload;
            if (cmd.set_hi) addr_q[BYTE_W-1:NIB_W] <= payload;
            if (cmd.hold)   hold_q                 <= payload;
            if (cmd.read)   out_data               <= rd_data;
            if (cmd.bump)   addr_q                 <= addr_q + 8'd1;
        end
    end

endmodule

// File: rtl/nibreg_port.sv
module nibreg_port
    import nrp_pkg::*;
#(
    parameter int NUM_RW     = 16,
    parameter int NUM_STATUS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [7:0]                   in_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [7:0]                   out_data,
    input  logic [NUM_STATUS*8-1:0]      status_in,
    output logic [NUM_RW*8-1:0]          reg_out
);

    cmd_t              cmd;
    logic [NIB_W-1:0]  payload;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;

    nrp_cmd_decode u_dec (
        .cmd_byte (in_data),
        .cmd      (cmd),
        .payload  (payload)
    );

    nrp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cmd       (cmd),
        .payload   (payload),
        .rd_data   (rd_data),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .addr_q    (addr_q),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    nrp_regbank #(
        .NUM_RW     (NUM_RW),
        .NUM_STATUS (NUM_STATUS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr_q),
        .wr_data   (wr_data),
        .status_in (status_in),
        .rd_data   (rd_data),
        .regs_flat (reg_out)
    );

endmodule

// File: rtl/nibreg_port_chk.sv
module nibreg_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [3:0] tag,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic [7:0] addr_q
);

    logic take;
    assign take = in_valid && in_ready;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready && addr_q == 8'h00));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_read_presents_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (tag == 4'h4 || tag == 4'h5)) |=> out_valid);

    assert_read_keeps_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag == 4'h4) |=> $stable(addr_q));

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag == 4'h5) |=> (addr_q == $past(addr_q) + 8'd1));

    assert_write_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag == 4'h3) |=> (addr_q == $past(addr_q) + 8'd1));

    assert_ignored_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag >= 4'h6) |=> ($stable(addr_q) && !out_valid));

endmodule

bind nibreg_port nibreg_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tag       (in_data[7:4]),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .addr_q    (addr_q)
);

// File: tb/nibreg_port_tb.sv
`timescale 1ns/1ps
module nibreg_port_tb;

    localparam int NUM_RW     = 16;
    localparam int NUM_STATUS = 8;
    localparam int WIDE       = NUM_RW * 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [7:0]              in_data = 8'h00;
    logic                    out_valid;
    logic                    out_ready = 1'b1;
    logic [7:0]              out_data;
    logic [NUM_STATUS*8-1:0] status_in;
    logic [WIDE-1:0]         reg_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_regs [NUM_RW];
    logic [7:0] m_addr;
    logic [3:0] m_hold;

    always #2 clk = ~clk;

    nibreg_port #(.NUM_RW(NUM_RW), .NUM_STATUS(NUM_STATUS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .status_in (status_in),
        .reg_out   (reg_out)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [WIDE-1:0] act, input logic [WIDE-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (int'(a) < NUM_RW) return m_regs[a];
        if (int'(a) < NUM_RW + NUM_STATUS) return status_in[(int'(a) - NUM_RW)*8 +: 8];
        return 8'h00;
    endfunction

    function automatic logic [WIDE-1:0] model_flat();
        logic [WIDE-1:0] f;
        for (int i = 0; i < NUM_RW; i++) f[i*8 +: 8] = m_regs[i];
        return f;
    endfunction

    // Issue one command; read results are checked, stall cycles hold the consumer off.
    task automatic do_cmd(input logic [7:0] b, input int stall, input string req);
        logic [3:0] t;
        logic [3:0] n;
        logic [7:0] exp;
        t = b[7:4];
        n = b[3:0];
        while (!in_ready) @(negedge clk);
        exp = model_read(m_addr);
        in_valid  = 1'b1;
        in_data   = b;
        out_ready = (stall == 0);
        @(negedge clk);
        in_valid = 1'b0;
        case (t)
            4'h0: m_addr[3:0] = n;
            4'h1: m_addr[7:4] = n;
            4'h2: m_hold = n;
            4'h3: begin
                if (int'(m_addr) < NUM_RW) m_regs[m_addr] = {n, m_hold};
                m_addr = m_addr + 8'd1;
            end
            4'h5: m_addr = m_addr + 8'd1;
            default: ;
        endcase
        if (t == 4'h4 || t == 4'h5) begin
            chk(out_valid == 1'b1, {req, " out_valid"}, WIDE'(out_valid), WIDE'(1));
            chk(out_data == exp, {req, " out_data"}, WIDE'(out_data), WIDE'(exp));
            for (int s = 1; s < stall; s++) begin
                @(negedge clk);
                chk(out_valid && out_data == exp && !in_ready, "R9 stall hold",
                    WIDE'({out_valid, in_ready, out_data}), WIDE'({2'b10, exp}));
            end
            out_ready = 1'b1;
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 release", WIDE'(out_valid), WIDE'(0));
        end else begin
            chk(out_valid == 1'b0, {req, " no output"}, WIDE'(out_valid), WIDE'(0));
        end
        chk(reg_out == model_flat(), {req, " R3 reg_out"}, reg_out, model_flat());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        for (int k = 0; k < NUM_STATUS; k++) status_in[k*8 +: 8] = 8'($urandom);
        for (int i = 0; i < NUM_RW; i++) m_regs[i] = 8'h00;
        m_addr = 8'h00;
        m_hold = 4'h0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 handshake in reset",
            WIDE'({out_valid, in_ready}), WIDE'(2'b01));
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_out == '0, "R1 registers cleared", reg_out, '0);
        do_cmd(8'h40, 0, "R1 addr zero read");
        do_cmd(8'h35, 0, "R10 hold reset zero");            // reg0 = 0x50

        // R2 / R3 / R4: address setup and a two-byte write run
        do_cmd(8'h03, 0, "R2");
        do_cmd(8'h10, 0, "R2");
        do_cmd(8'h2A, 0, "R3");
        do_cmd(8'h3B, 0, "R3");                               // reg3 = 0xBA
        do_cmd(8'h21, 0, "R4");
        do_cmd(8'h3C, 0, "R4");                               // reg4 = 0xC1
        do_cmd(8'h3D, 0, "R10 reuse hold");                   // reg5 = 0xD1
        do_cmd(8'h03, 0, "R2");
        do_cmd(8'h54, 0, "R6 burst");
        do_cmd(8'h54, 0, "R6 burst");
        do_cmd(8'h54, 0, "R6 burst");
        do_cmd(8'h44, 0, "R5 plain read");
        do_cmd(8'h44, 0, "R5 address kept");

        // R7: status region burst, write attempt, unmapped read
        do_cmd(8'h00, 0, "R2");
        do_cmd(8'h11, 0, "R2");
        for (int i = 0; i < 6; i++) do_cmd(8'h50, 0, "R7 status burst");
        do_cmd(8'h02, 0, "R2");
        do_cmd(8'h2F, 0, "R7");
        do_cmd(8'h3F, 0, "R7 write to status ignored");
        do_cmd(8'h02, 0, "R2");
        do_cmd(8'h40, 0, "R7 status unchanged");
        do_cmd(8'h12, 0, "R2");
        do_cmd(8'h40, 0, "R7 unmapped reads zero");

        // R8: ignored tags between hold and commit
        do_cmd(8'h02, 0, "R2");
        do_cmd(8'h10, 0, "R2");
        do_cmd(8'h27, 0, "R3");
        do_cmd(8'h6F, 0, "R8 ignored");
        do_cmd(8'hF0, 0, "R8 ignored");
        do_cmd(8'h93, 0, "R8 ignored");
        do_cmd(8'h31, 0, "R8 hold kept");                     // reg2 = 0x17
        do_cmd(8'h40, 0, "R8 address kept");                  // reads reg3

        // R9: back-pressure
        do_cmd(8'h02, 0, "R2");
        do_cmd(8'h40, 5, "R9 stalled read");

        // R4: wrap from 0xFF
        do_cmd(8'h0F, 0, "R2");
        do_cmd(8'h1F, 0, "R2");
        do_cmd(8'h20, 0, "R4");
        do_cmd(8'h30, 0, "R4 wrap");
        do_cmd(8'h40, 0, "R4 wrapped to zero");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] t;
            logic [3:0] n;
            int st;
            t  = ($urandom % 5 == 0) ? 4'($urandom) : 4'($urandom % 6);
            n  = (t == 4'h1) ? 4'($urandom % 3) : 4'($urandom);
            st = ($urandom % 3 == 0) ? int'($urandom % 4) : 0;
            do_cmd({t, n}, st, "R2 R5 R6 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule